// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block collects the interrupt causes of a 16550-style serial port and reduces them to one prioritized identification byte and one interrupt line. Receive line errors, received data, character timeout, transmitter data requests and modem line changes each have a pending condition. The block sets and clears each one from status levels and one-cycle strobes, gates it with its own enable bit, and reports the most urgent enabled one in the low nibble of the identification byte. The upper bits of the byte are not prioritized. They show whether the FIFOs are enabled and whether the automatic baud-rate detector has locked.

The serial shifters, FIFO storage, baud generator, baud measurement and the register file are outside the block. The block sees them only as levels such as FIFO occupancy and trigger level, and as one-cycle strobes that mark register reads and writes from the host port. The identification byte and the interrupt output are combinational from registered state and the current inputs. A strobe takes effect at the next clock edge.

Top module: `uart_iid_top`

## Requirements
- R1: After reset, with no source pending, the low nibble `iir[3:0]` reads 0001 and `irq` is 0.
- R2: An enabled line error is always reported first, as nibble 0110, whatever else is pending.
- R3: The line error condition is set by any bit of `line_err` (overrun, parity, framing, break) and cleared by `lsr_rd`. When both arrive in the same cycle, the condition stays set.
- R4: Received data is reported as nibble 0100. In FIFO mode the condition is a nonzero `rx_level` that is at least `rx_trig`. In non-FIFO mode it is `rx_full`. The condition follows these levels with no memory.
- R5: A character timeout is latched by `rx_tmo` only in FIFO mode and only while `rx_level` is nonzero. It is reported as nibble 1100 (bit 3 on top of the received-data code). It is cleared by `rx_rd` or `rx_flush`, and by leaving FIFO mode. `rx_flush` wins over a new timeout.
- R6: A transmit request latches when its condition rises. In FIFO mode the condition is `tx_level` at most half of `FIFO_DEPTH`. In non-FIFO mode it is `thr_empty`. The request is reported as nibble 0010, below received data.
- R7: The transmit request is cleared by `tx_wr`, or by `iir_rd` in a cycle where the nibble shows 0010. An `iir_rd` while another source is shown leaves it pending. A rise in the same cycle as a clear keeps it set.
- R8: A modem line change (`modem_chg`) is the lowest source, reported as nibble 0000. It is cleared by `msr_rd`, and a change in the same cycle as the read keeps it set.
- R9: `ien` gates the reporting of each source. Bit 0 gates received data and timeout, bit 1 the transmit request, bit 2 the line error, bit 3 modem change. A source that is disabled still latches and appears once it is enabled.
- R10: `iir[4]` equals `baud_locked`, `iir[5]` is 0, and `iir[7:6]` both equal `fifo_mode`.
- R11: `irq` is high exactly when `iir[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | FIFOs enabled |
| ien | input | 4 | Per-source enables: rx, tx, line, modem |
| line_err | input | 4 | Error strobes: overrun, parity, framing, break |
| modem_chg | input | 1 | Modem line change strobe |
| rx_full | input | 1 | Receive holding register full (non-FIFO mode) |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_trig | input | LVL_W | Receive trigger level |
| rx_tmo | input | 1 | Character timeout strobe from the receive timer |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_flush | input | 1 | Receive FIFO reset strobe |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| thr_empty | input | 1 | Transmit holding register empty (non-FIFO mode) |
| tx_wr | input | 1 | Transmit holding register / FIFO write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| baud_locked | input | 1 | Baud detector has written the divisor |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with `FIFO_DEPTH` = 8, which gives a 4-bit level and a half-full mark of 4. A short walk of `tx_level` therefore crosses the 4/5 boundary in both directions, and `rx_level` can reach the full depth. With these small values, random runs often hit the empty-FIFO timeout case, trigger levels of 0 and the full depth, and pile-ups where several sources are pending together. The directed part of the run exercises the same-cycle set/clear races of every latched source.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  // Source code carried in iir[2:1]
  typedef enum logic [1:0] {
    SRC_MODEM  = 2'b00,
    SRC_TXREQ  = 2'b01,
    SRC_RXDATA = 2'b10,
    SRC_LINE   = 2'b11
  } iid_src_e;

  // Positions inside the enable vector
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_W     = 4;

  // Number of sticky set/clear sources (line error, modem change)
  localparam int N_STICKY = 2;
  localparam int STK_LINE  = 0;
  localparam int STK_MODEM = 1;

  typedef struct packed {
    logic line;
    logic rxdata;
    logic timeout;
    logic txreq;
    logic modem;
  } iid_req_t;

  localparam logic [3:0] NIB_IDLE = 4'b0001;

  // Priority encode the enabled requests into the low nibble.
  function automatic logic [3:0] iid_encode(iid_req_t r);
    logic [3:0] nib;
    if (r.line)
      nib = {1'b0, SRC_LINE, 1'b0};
    else if (r.rxdata || r.timeout)
      nib = {r.timeout, SRC_RXDATA, 1'b0};
    else if (r.txreq)
      nib = {1'b0, SRC_TXREQ, 1'b0};
    else if (r.modem)
      nib = {1'b0, SRC_MODEM, 1'b0};
    else
      nib = NIB_IDLE;
    return nib;
  endfunction

endpackage

// File: rtl/uart_iid_sticky.sv
module uart_iid_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  // A set in the same cycle as a clear keeps the flag
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  // R3 / R8: a set always lands, even against a clear
  p_sticky_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R3 / R8: a lone clear drops the flag
  p_sticky_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

  // R3 / R8: without either strobe the flag keeps its value
  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i && flag_o) |=> flag_o);

endmodule

// File: rtl/uart_iid_rx.sv
module uart_iid_rx #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             rx_full,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_tmo,
  input  logic             rx_rd,
  input  logic             rx_flush,
  output logic             data_ready_o,
  output logic             tmo_o
);

  // Trigger reached: something stored and at or above the trigger level
  function automatic logic level_reached(logic [LVL_W-1:0] lvl,
                                         logic [LVL_W-1:0] trig);
    return (lvl != '0) && (lvl >= trig);
  endfunction

  logic tmo_q;
  logic fifo_nonempty_w;
  logic tmo_set_w;
  logic tmo_keep_w;

  assign fifo_nonempty_w = (rx_level != '0);
  assign data_ready_o    = fifo_mode ? level_reached(rx_level, rx_trig) : rx_full;

  // Timeout is a FIFO-mode feature; a flush beats a new timeout
  assign tmo_set_w  = fifo_mode & rx_tmo & fifo_nonempty_w & ~rx_flush;
  assign tmo_keep_w = fifo_mode & tmo_q & ~rx_rd & ~rx_flush;

  always_ff @(posedge clk) begin
    if (!rst_n) tmo_q <= 1'b0;
    else        tmo_q <= tmo_set_w | tmo_keep_w;
  end

  assign tmo_o = tmo_q;

  // R5: flush always clears the timeout
  p_tmo_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !tmo_o);

  // R5: no timeout survives outside FIFO mode
  p_tmo_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !tmo_o);

  // R5: a timeout strobe on an empty FIFO creates nothing
  p_tmo_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tmo && !fifo_nonempty_w && !tmo_o) |=> !tmo_o);

  // R4: in non-FIFO mode the ready level tracks the full flag
  p_nf_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !rx_full) |-> !data_ready_o);

endmodule

// File: rtl/uart_iid_tx.sv
module uart_iid_tx #(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             thr_empty,
  input  logic             tx_wr,
  input  logic             iir_rd,
  input  logic             tx_shown,
  output logic             req_o,
  output logic             rise_o
);

  localparam logic [LVL_W-1:0] HALF_MARK = LVL_W'(FIFO_DEPTH / 2);

  // Room for at least half the FIFO
  function automatic logic has_room(logic [LVL_W-1:0] lvl);
    return lvl <= HALF_MARK;
  endfunction

  logic cond_w;
  logic cond_q;
  logic req_q;
  logic ack_w;

  assign cond_w = fifo_mode ? has_room(tx_level) : thr_empty;
  assign rise_o = cond_w & ~cond_q;
  assign ack_w  = tx_wr | (iir_rd & tx_shown);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      cond_q <= cond_w;
      req_q  <= rise_o | (req_q & ~ack_w);
    end
  end

  assign req_o = req_q;

  // R6: a rising condition raises the request
  p_tx_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> req_o);

  // R7: a write without a new rise drops the request
  p_tx_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !rise_o) |=> !req_o);

  // R7: reading the identification while another source shows keeps it
  p_tx_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && iir_rd && !tx_shown && !tx_wr) |=> req_o);

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_iid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_rep,
  input  logic       rx_rep,
  input  logic       tmo_rep,
  input  logic       tx_rep,
  input  logic       modem_rep,
  input  logic       fifo_mode,
  input  logic       baud_locked,
  output logic [7:0] iir_o,
  output logic       tx_shown_o
);

  iid_req_t   req_w;
  logic [3:0] nib_w;

  assign req_w.line    = line_rep;
  assign req_w.rxdata  = rx_rep;
  assign req_w.timeout = tmo_rep;
  assign req_w.txreq   = tx_rep;
  assign req_w.modem   = modem_rep;

  assign nib_w      = iid_encode(req_w);
  assign tx_shown_o = (nib_w == {1'b0, SRC_TXREQ, 1'b0});

  // Upper bits carry mode and lock status, not priority
  assign iir_o = {fifo_mode, fifo_mode, 1'b0, baud_locked, nib_w};

  // R2: line error masks everything below
  p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_rep |-> (iir_o[3:0] == 4'b0110));

  // R1: nothing requested reads idle
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_rep || rx_rep || tmo_rep || tx_rep || modem_rep) |-> (iir_o[3:0] == 4'b0001));

  // R6: receive side outranks the transmit request
  p_rx_over_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rep && !line_rep) |-> !tx_shown_o);

  // R8: modem only shows when it is the sole request
  p_modem_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_o[3:0] == 4'b0000) |-> (modem_rep && !line_rep && !rx_rep && !tx_rep));

endmodule

// File: rtl/uart_iid_top.sv
module uart_iid_top
  import uart_iid_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [EN_W-1:0]  ien,
  input  logic [3:0]       line_err,
  input  logic             modem_chg,
  input  logic             rx_full,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_tmo,
  input  logic             rx_rd,
  input  logic             rx_flush,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             thr_empty,
  input  logic             tx_wr,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             baud_locked,
  output logic [7:0]       iir,
  output logic             irq
);

  // Sticky sources: line error and modem change
  logic [N_STICKY-1:0] stk_set_w;
  logic [N_STICKY-1:0] stk_clr_w;
  logic [N_STICKY-1:0] stk_flag_w;

  assign stk_set_w[STK_LINE]  = |line_err;
  assign stk_clr_w[STK_LINE]  = lsr_rd;
  assign stk_set_w[STK_MODEM] = modem_chg;
  assign stk_clr_w[STK_MODEM] = msr_rd;

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    uart_iid_sticky u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (stk_set_w[g]),
      .clr_i  (stk_clr_w[g]),
      .flag_o (stk_flag_w[g])
    );
  end

  logic rx_ready_w;
  logic tmo_w;
  logic tx_req_w;
  logic tx_rise_w;
  logic tx_shown_w;

  uart_iid_rx #(.LVL_W(LVL_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode    (fifo_mode),
    .rx_full      (rx_full),
    .rx_level     (rx_level),
    .rx_trig      (rx_trig),
    .rx_tmo       (rx_tmo),
    .rx_rd        (rx_rd),
    .rx_flush     (rx_flush),
    .data_ready_o (rx_ready_w),
    .tmo_o        (tmo_w)
  );

  uart_iid_tx #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .tx_level  (tx_level),
    .thr_empty (thr_empty),
    .tx_wr     (tx_wr),
    .iir_rd    (iir_rd),
    .tx_shown  (tx_shown_w),
    .req_o     (tx_req_w),
    .rise_o    (tx_rise_w)
  );

  // Enable gating: latched state is kept, only reporting is masked
  logic line_rep_w, rx_rep_w, tmo_rep_w, tx_rep_w, modem_rep_w;

  assign line_rep_w  = stk_flag_w[STK_LINE]  & ien[EN_LINE];
  assign modem_rep_w = stk_flag_w[STK_MODEM] & ien[EN_MODEM];
  assign tmo_rep_w   = tmo_w & ien[EN_RX];
  assign rx_rep_w    = rx_ready_w & ien[EN_RX];
  assign tx_rep_w    = tx_req_w & ien[EN_TX];

  uart_iid_prio u_prio (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_rep    (line_rep_w),
    .rx_rep      (rx_rep_w),
    .tmo_rep     (tmo_rep_w),
    .tx_rep      (tx_rep_w),
    .modem_rep   (modem_rep_w),
    .fifo_mode   (fifo_mode),
    .baud_locked (baud_locked),
    .iir_o       (iir),
    .tx_shown_o  (tx_shown_w)
  );

  assign irq = ~iir[0];

  // R11: a raised interrupt always has an enabled cause behind it
  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (line_rep_w || rx_rep_w || tmo_rep_w || tx_rep_w || modem_rep_w));

  // R7: reading the identification while it shows the transmit code acks it
  p_iir_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir[3:0] == 4'b0010 && !tx_rise_w) |=> !tx_req_w);

  // R9: a masked line error is never shown
  p_mask_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ien[EN_LINE] |-> (iir[3:0] != 4'b0110));

  // R5: the timeout bit only appears with the received-data code
  p_tmo_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iir[3] |-> (iir[2:0] == 3'b100));

  // R10: reserved bit stays low
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !iir[5]);

endmodule

// File: tb/uart_iid_top_tb_top.sv
`timescale 1ns/1ps
module uart_iid_top_tb_top;

  localparam int DEPTH = 8;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fifo_mode;
  logic [3:0]    ien;
  logic [3:0]    line_err;
  logic          modem_chg;
  logic          rx_full;
  logic [LW-1:0] rx_level;
  logic [LW-1:0] rx_trig;
  logic          rx_tmo;
  logic          rx_rd;
  logic          rx_flush;
  logic [LW-1:0] tx_level;
  logic          thr_empty;
  logic          tx_wr;
  logic          iir_rd;
  logic          lsr_rd;
  logic          msr_rd;
  logic          baud_locked;
  logic [7:0]    iir;
  logic          irq;

  always #2 clk = ~clk;   // 250 MHz

  uart_iid_top #(.FIFO_DEPTH(DEPTH), .LVL_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ien(ien),
    .line_err(line_err), .modem_chg(modem_chg), .rx_full(rx_full),
    .rx_level(rx_level), .rx_trig(rx_trig), .rx_tmo(rx_tmo),
    .rx_rd(rx_rd), .rx_flush(rx_flush), .tx_level(tx_level),
    .thr_empty(thr_empty), .tx_wr(tx_wr), .iir_rd(iir_rd),
    .lsr_rd(lsr_rd), .msr_rd(msr_rd), .baud_locked(baud_locked),
    .iir(iir), .irq(irq)
  );

  int n_vec  = 0;
  int n_miss = 0;
  string cur_req = "R1";

  // Reference state
  bit m_line, m_modem, m_tmo, m_tx, m_cond_prev;

  function automatic bit m_rx_avail();
    if (fifo_mode) return (int'(rx_level) > 0) && (int'(rx_level) >= int'(rx_trig));
    return rx_full;
  endfunction

  function automatic bit m_tx_cond();
    if (fifo_mode) return int'(tx_level) * 2 <= DEPTH;
    return thr_empty;
  endfunction

  function automatic logic [3:0] m_nibble();
    if (m_line && ien[2]) return 4'b0110;
    if ((m_rx_avail() || m_tmo) && ien[0]) return m_tmo ? 4'b1100 : 4'b0100;
    if (m_tx && ien[1]) return 4'b0010;
    if (m_modem && ien[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic logic [7:0] m_iir();
    return {fifo_mode, fifo_mode, 1'b0, baud_locked, m_nibble()};
  endfunction

  task automatic compare();
    logic [7:0] e;
    e = m_iir();
    n_vec++;
    if (iir[3:0] !== e[3:0]) begin
      n_miss++;
      $display("FAIL %s nibble: got %b expected %b", cur_req, iir[3:0], e[3:0]);
    end
    if (iir[7:4] !== e[7:4]) begin  // R10
      n_miss++;
      $display("FAIL R10 upper bits: got %b expected %b", iir[7:4], e[7:4]);
    end
    if (irq !== ~e[0]) begin        // R11
      n_miss++;
      $display("FAIL R11 irq: got %b expected %b", irq, ~e[0]);
    end
  endtask

  task automatic model_step();
    logic [3:0] nib;
    bit cond, lvl_nz;
    nib    = m_nibble();
    cond   = m_tx_cond();
    lvl_nz = (rx_level != '0);
    m_line  = (|line_err) || (m_line && !lsr_rd);
    m_modem = modem_chg || (m_modem && !msr_rd);
    m_tmo   = fifo_mode && !rx_flush && ((rx_tmo && lvl_nz) || (m_tmo && !rx_rd));
    m_tx    = (cond && !m_cond_prev) || (m_tx && !tx_wr && !(iir_rd && nib == 4'b0010));
    m_cond_prev = cond;
  endtask

  // One clock: inputs already set after a falling edge
  task automatic cyc();
    #1;
    if (rst_n) compare();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
  endtask

  task automatic strobes_off();
    line_err = 4'h0; modem_chg = 0; rx_tmo = 0; rx_rd = 0; rx_flush = 0;
    tx_wr = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0;
  endtask

  task automatic pulse_cyc();
    cyc();
    strobes_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    rst_n = 0; fifo_mode = 0; ien = 0; rx_full = 0; rx_level = 0; rx_trig = 1;
    tx_level = DEPTH[LW-1:0]; thr_empty = 0; baud_locked = 0;
    strobes_off();
    m_line = 0; m_modem = 0; m_tmo = 0; m_tx = 0; m_cond_prev = 0;
    @(negedge clk);
    repeat (3) cyc();
    rst_n = 1;
    // R1: idle after reset
    cur_req = "R1";
    n_vec++;
    if (iir !== 8'h01 || irq !== 1'b0) begin
      n_miss++;
      $display("FAIL R1 reset: got %h/%b expected 01/0", iir, irq);
    end
    repeat (2) cyc();

    // R10: upper bits follow mode and lock; tx request latches masked (R9)
    cur_req = "R10";
    baud_locked = 1; fifo_mode = 1; tx_level = 0;
    repeat (2) cyc();
    // R9 / R6: enabling shows the already latched transmit request
    cur_req = "R9";
    ien = 4'hF;
    cyc();
    // R7: reading identification while tx shown clears it
    cur_req = "R7";
    iir_rd = 1; pulse_cyc(); cyc();
    // R6: boundary 4 (half) vs 5
    cur_req = "R6";
    tx_level = 4; cyc();
    tx_level = 5; cyc();
    tx_level = 4; cyc(); cyc();
    // R7: write clears; rise with write same cycle keeps
    cur_req = "R7";
    tx_wr = 1; pulse_cyc(); cyc();
    tx_level = 6; cyc();
    tx_level = 2; tx_wr = 1; pulse_cyc(); cyc();
    // R4: trigger level crossing, outranks tx
    cur_req = "R4";
    rx_trig = 4; rx_level = 3; cyc();
    rx_level = 4; cyc();
    // R7: iir read while rx shown keeps tx pending
    cur_req = "R7";
    iir_rd = 1; pulse_cyc();
    cur_req = "R4";
    rx_level = 3; cyc(); cyc();
    // R5: timeout with data, cleared by read
    cur_req = "R5";
    rx_tmo = 1; pulse_cyc(); cyc();
    rx_rd = 1; pulse_cyc(); cyc();
    rx_tmo = 1; rx_flush = 1; pulse_cyc(); cyc();
    rx_tmo = 1; rx_rd = 1; pulse_cyc(); cyc();
    rx_flush = 1; pulse_cyc(); cyc();
    rx_level = 0; rx_tmo = 1; pulse_cyc(); cyc();
    rx_level = 2; rx_tmo = 1; pulse_cyc();
    fifo_mode = 0; cyc(); cyc();
    rx_tmo = 1; pulse_cyc(); cyc();
    fifo_mode = 1; cyc();
    // R3 / R2: each error bit, line first, same-cycle set wins
    for (int b = 0; b < 4; b++) begin
      cur_req = "R2";
      line_err = 4'(1 << b); pulse_cyc(); cyc();
      cur_req = "R3";
      lsr_rd = 1; pulse_cyc(); cyc();
    end
    line_err = 4'h2; lsr_rd = 1; pulse_cyc(); cyc();
    lsr_rd = 1; pulse_cyc(); cyc();
    // R8: modem lowest
    cur_req = "R8";
    tx_wr = 1; pulse_cyc();
    rx_level = 0;
    modem_chg = 1; pulse_cyc(); cyc();
    msr_rd = 1; modem_chg = 1; pulse_cyc(); cyc();
    msr_rd = 1; pulse_cyc(); cyc();
    // R9: masked sources latch and appear later
    cur_req = "R9";
    ien = 4'h0;
    line_err = 4'h8; modem_chg = 1; pulse_cyc(); cyc();
    ien = 4'h8; cyc();
    ien = 4'hC; cyc();
    lsr_rd = 1; msr_rd = 1; pulse_cyc(); cyc();
    ien = 4'hF;
    // R4 / R6: non-FIFO levels
    cur_req = "R4";
    fifo_mode = 0; rx_full = 1; cyc();
    rx_full = 0; cyc();
    cur_req = "R6";
    thr_empty = 1; cyc(); cyc();
    tx_wr = 1; thr_empty = 0; pulse_cyc(); cyc();

    // Random mix across all requirements
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) fifo_mode = ~fifo_mode;
      if ($urandom_range(0, 29) == 0) ien = 4'($urandom);
      if ($urandom_range(0, 99) == 0) baud_locked = ~baud_locked;
      rx_level  = LW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 9) == 0) rx_trig = LW'($urandom_range(0, DEPTH));
      tx_level  = LW'($urandom_range(0, DEPTH));
      rx_full   = 1'($urandom);
      thr_empty = 1'($urandom);
      line_err  = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'h0;
      modem_chg = ($urandom_range(0, 9) == 0);
      rx_tmo    = ($urandom_range(0, 5) == 0);
      rx_rd     = ($urandom_range(0, 5) == 0);
      rx_flush  = ($urandom_range(0, 19) == 0);
      tx_wr     = ($urandom_range(0, 5) == 0);
      iir_rd    = ($urandom_range(0, 3) == 0);
      lsr_rd    = ($urandom_range(0, 5) == 0);
      msr_rd    = ($urandom_range(0, 5) == 0);
      pulse_cyc();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule